// File: doc/BRIEF.md
# Serial Configuration Port for a Line-Receiver Controller

This block is the device-side end of a four-wire serial link. It gives a host read and write access to a small bank of 8-bit control registers. The host pulls the active-low select low, clocks out a direction flag and a 7-bit register address, and then either sends one data byte or receives one. The block runs entirely on its own system clock. It brings the serial clock, select and data-in lines through synchronisers and finds the serial clock edges by oversampling. A serial clock of at most one sixth of the system clock keeps the margins comfortable.

Two fields in the bank are not stored values. They reflect status inputs from the rest of the receiver: a carrier-present flag, and a 5-bit estimate of cable length that saturates at 25. The writable contents of all registers, with the status fields merged in, are also driven out as a flat bus so that the surrounding receiver logic can use them. A register-access enable input switches the port off completely, which leaves the receiver under strap-pin control.

Top module: `linerx_cfg_spi`

## Requirements
- R1: A frame is 16 serial clock periods while select is low. Bit 15 is the direction (0 = write, 1 = read), bits 14..8 are the address sent most significant bit first, and bits 7..0 are the data sent most significant bit first. The device samples `mosi` on the rising serial clock edge and changes `miso` on the falling edge (clock idles low).
- R2: A complete write frame to address 00h..04h replaces the writable bits of that register. The new value appears both on `reg_bus` (register n at bits 8n+7..8n) and in the next read.
- R3: A read frame returns the register on `miso` with D7 first. D7 is driven from the falling edge that follows the eighth rising edge, and each later falling edge moves to the next bit down.
- R4: `miso_oe` is 0 while select is high, throughout a write frame, and during the direction and address bits of a read. It is 1 from the falling edge after the eighth rising edge until the falling edge after the sixteenth.
- R5: Register 00h bit 7 reads as `carrier_det` and ignores writes. Bits 6..0 are writable.
- R6: Register 03h bits 7..3 read as `len_ind` clamped to a maximum of 25 (an input of 26..31 reads as 25) and ignore writes. Bits 2..0 are writable.
- R7: Addresses 05h..7Fh are unimplemented. Writes to them change no register, and reads from them return 00h.
- R8: A frame in which select rises before the sixteenth rising edge changes no register. The next frame is decoded from its own first bit.
- R9: While `reg_en` is 0, frames are ignored: no register changes and `miso_oe` stays 0.
- R10: The synchronous reset sets the writable bits to 00h: 21h, 01h: 30h, 02h: 58h, 03h: 101b (bits 2..0), 04h: 88h, and sets `miso_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | 1 enables register access, 0 selects strap-pin operation |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| carrier_det | input | 1 | Carrier-present status |
| len_ind | input | 5 | Cable length estimate |
| miso | output | 1 | Serial read data |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| reg_bus | output | 40 | All five registers as read, register n at bits 8n+7..8n |

## Verification
The bench goes after frame boundaries. Frames abandoned after 12 and after 15 bits must leave the target register alone. A design that committed on a partial shift, or failed to clear its bit counter on select release, would corrupt the register or misframe the next transaction.

It also sweeps every unimplemented address for both writes and reads. This catches an address decode that only looks at the low three bits, which would alias writes onto real registers and return non-zero reads.

The length field is swept over all 32 input codes, so a missing clamp shows up as a reading above 25. The read-only bits are written with ones, so a design that stored them would show the written value instead of the status.

The output enable is sampled at every bit of every frame. This catches a `miso` that is driven during a write or during the address phase, or that is still enabled when strap mode is selected.

// File: rtl/linerx_spi_pkg.sv
package linerx_spi_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int NREG       = 5;
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int BUS_W      = NREG * DATA_W;

  // status overlays
  localparam int CD_REG  = 0;
  localparam int CD_BIT  = 7;
  localparam int LEN_REG = 3;
  localparam int LEN_LSB = 3;
  localparam int LEN_W   = 5;
  localparam int LEN_MAX = 25;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h21;
      1:       return 8'h30;
      2:       return 8'h58;
      3:       return 8'h05;
      4:       return 8'h88;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_wmask(input int idx);
    logic [DATA_W-1:0] m;
    m = '1;
    if (idx == CD_REG)  m[CD_BIT] = 1'b0;
    if (idx == LEN_REG) m[LEN_LSB +: LEN_W] = '0;
    return m;
  endfunction
endpackage

// File: rtl/linerx_spi_sync.sv
module linerx_spi_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/linerx_spi_frame.sv
module linerx_spi_frame
  import linerx_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic                    sclk_prev_q;
  logic                    rise, fall, act;
  logic [CNT_W-1:0]        cnt_q;
  logic [FRAME_BITS-2:0]   shin_q;
  logic [DATA_W-1:0]       shout_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev_q <= 1'b0;
    else     sclk_prev_q <= sclk_i;
  end

  assign rise = sclk_i & ~sclk_prev_q;
  assign fall = ~sclk_i & sclk_prev_q;
  assign act  = en_i & ~csn_i;

  assign rd_addr_o = shin_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !act) begin
      cnt_q     <= '0;
      shin_q    <= '0;
      shout_q   <= '0;
      miso_o    <= 1'b0;
      miso_oe_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (rise && cnt_q < CNT_FULL) begin
        shin_q <= {shin_q[FRAME_BITS-3:0], mosi_i};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST && !shin_q[FRAME_BITS-2]) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= shin_q[DATA_W+ADDR_W-2 : DATA_W-1];
          wr_data_o <= {shin_q[DATA_W-2:0], mosi_i};
        end
      end
      if (fall) begin
        if (cnt_q == CNT_HDR && shin_q[ADDR_W]) begin
          miso_oe_o <= 1'b1;
          miso_o    <= rd_data_i[DATA_W-1];
          shout_q   <= {rd_data_i[DATA_W-2:0], 1'b0};
        end else if (miso_oe_o && cnt_q < CNT_FULL) begin
          miso_o  <= shout_q[DATA_W-1];
          shout_q <= {shout_q[DATA_W-2:0], 1'b0};
        end else if (cnt_q == CNT_FULL) begin
          miso_oe_o <= 1'b0;
          miso_o    <= 1'b0;
        end
      end
    end
  end

  // R4: select release tri-states the output on the next cycle
  p_oe_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !act |=> !miso_oe_o);
  // R4: output enabled only once the address phase is over
  p_oe_phase_r4: assert property (@(posedge clk) disable iff (rst)
    miso_oe_o |-> (cnt_q >= CNT_HDR));
  // R8: a commit only follows the full frame
  p_commit_full_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (cnt_q == CNT_FULL));
endmodule

// File: rtl/linerx_spi_regbank.sv
module linerx_spi_regbank
  import linerx_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              cd_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [BUS_W-1:0]  view_o
);
  logic              cd_q;
  logic [LEN_W-1:0]  len_q;
  logic [BUS_W-1:0]  store_flat;

  // status capture, clamped to the legal range
  always_ff @(posedge clk) begin
    cd_q  <= cd_i;
    len_q <= (len_i > LEN_W'(LEN_MAX)) ? LEN_W'(LEN_MAX) : len_i;
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DATA_W-1:0] MASK = reg_wmask(i);
      logic [DATA_W-1:0] store_q;
      logic [DATA_W-1:0] view;

      always_ff @(posedge clk) begin
        if (rst) store_q <= reg_default(i) & MASK;
        else if (wr_en_i && wr_addr_i == ADDR_W'(i)) store_q <= wr_data_i & MASK;
      end

      always_comb begin
        view = store_q;
        if (i == CD_REG)  view[CD_BIT] = cd_q;
        if (i == LEN_REG) view[LEN_LSB +: LEN_W] = len_q;
      end

      assign view_o[i*DATA_W +: DATA_W]     = view;
      assign store_flat[i*DATA_W +: DATA_W] = store_q;
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = view_o[i*DATA_W +: DATA_W];
  end

  // R7: writes outside the bank leave every register untouched
  p_unimpl_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i >= ADDR_W'(NREG)) |=> $stable(store_flat));
  // R6: reported length never exceeds the bound
  p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
    view_o[LEN_REG*DATA_W + LEN_LSB +: LEN_W] <= LEN_W'(LEN_MAX));
endmodule

// File: rtl/linerx_cfg_spi.sv
module linerx_cfg_spi
  import linerx_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_en,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic             carrier_det,
  input  logic [LEN_W-1:0] len_ind,
  output logic             miso,
  output logic             miso_oe,
  output logic [BUS_W-1:0] reg_bus
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  linerx_spi_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sclk, cs_n, mosi}),
    .q_o (pins_s)
  );

  linerx_spi_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .en_i      (reg_en),
    .sclk_i    (pins_s[2]),
    .csn_i     (pins_s[1]),
    .mosi_i    (pins_s[0]),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .miso_o    (miso),
    .miso_oe_o (miso_oe)
  );

  linerx_spi_regbank u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .cd_i      (carrier_det),
    .len_i     (len_ind),
    .rd_data_o (rd_data),
    .view_o    (reg_bus)
  );

  // R9: strap mode keeps the output released
  p_mode_off_r9: assert property (@(posedge clk) disable iff (rst)
    !reg_en |=> !miso_oe);
  // R5: carrier flag tracks its input one cycle later
  p_cd_track_r5: assert property (@(posedge clk) disable iff (rst)
    reg_bus[CD_REG*DATA_W + CD_BIT] == $past(carrier_det));
endmodule

// File: tb/linerx_cfg_spi_tb.sv
module linerx_cfg_spi_tb_top;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_en = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        carrier_det = 1'b0;
  logic [4:0]  len_ind = 5'd0;
  logic        miso, miso_oe;
  logic [39:0] reg_bus;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] wval [5];

  always #4 clk = ~clk;

  linerx_cfg_spi dut_i (
    .clk(clk), .rst(rst), .reg_en(reg_en), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .carrier_det(carrier_det), .len_ind(len_ind),
    .miso(miso), .miso_oe(miso_oe), .reg_bus(reg_bus)
  );

  task automatic chk(input bit ok, input string req, input logic [39:0] act,
                     input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(input int a);
    if (a == 0) return 8'h7F;
    if (a == 3) return 8'h07;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    logic [7:0] v;
    if (a > 4) return 8'h00;
    v = wval[a];
    if (a == 0) v[7] = carrier_det;
    if (a == 3) v[7:3] = (len_ind > 5'd25) ? 5'd25 : len_ind;
    return v;
  endfunction

  function automatic logic [39:0] exp_bus();
    logic [39:0] b;
    for (int i = 0; i < 5; i++) b[i*8 +: 8] = exp_rd(i);
    return b;
  endfunction

  // one frame; oe checked before every rising edge and after select release
  task automatic xfer(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                      input int nbits, input bit live,
                      output logic [7:0] rdv, output bit oe_ok);
    logic [15:0] fr;
    bit exp_oe;
    fr = {rd, a, wd};
    rdv = 8'h00;
    oe_ok = 1;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = fr[15-i];
      repeat (HALF) @(negedge clk);
      exp_oe = live && rd && (i >= 8);
      if (miso_oe !== exp_oe) oe_ok = 0;
      if (i >= 8) rdv[15-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    if (nbits == 16 && miso_oe !== 1'b0) oe_ok = 0;
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    if (miso_oe !== 1'b0) oe_ok = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic [7:0] dummy;
    bit ok;
    xfer(1'b0, 7'(a), d, 16, 1'b1, dummy, ok);
    if (a < 5) wval[a] = d & wmask(a);
    chk(ok, "R4 oe low in write frame", {39'd0, ok}, 40'd1);
  endtask

  task automatic rd_chk(input int a, input string req);
    logic [7:0] v;
    bit ok;
    xfer(1'b1, 7'(a), 8'h00, 16, 1'b1, v, ok);
    chk(v === exp_rd(a), req, {32'd0, v}, {32'd0, exp_rd(a)});
    chk(ok, "R4 oe window in read frame", {39'd0, ok}, 40'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [5];
    logic [7:0] v;
    bit ok;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h5A; pats[4] = 8'h3C;
    wval[0] = 8'h21; wval[1] = 8'h30; wval[2] = 8'h58;
    wval[3] = 8'h05; wval[4] = 8'h88;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(reg_bus === exp_bus(), "R10 reset register view", reg_bus, exp_bus());
    chk(miso_oe === 1'b0, "R10 oe low after reset", {39'd0, miso_oe}, 40'd0);
    for (int a = 0; a < 5; a++) rd_chk(a, "R10 default readback");

    // R1 R2 R3 write/read patterns on every register
    for (int p = 0; p < 5; p++)
      for (int a = 0; a < 5; a++) begin
        wr(a, pats[p] ^ 8'(a * 8'h11));
        rd_chk(a, "R1/R2/R3 readback after write");
        chk(reg_bus === exp_bus(), "R2 register bus after write", reg_bus, exp_bus());
      end

    // R5 carrier flag, bit 7 of register 0 ignores writes
    wr(0, 8'hFF);
    carrier_det = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(0, "R5 carrier flag set");
    wr(0, 8'h00);
    rd_chk(0, "R5 write of bit7 ignored, flag still set");
    carrier_det = 1'b0;
    wr(0, 8'h80);
    rd_chk(0, "R5 carrier flag clear");

    // R6 length field clamp sweep, writes to it ignored
    wr(3, 8'hFF);
    for (int l = 0; l < 32; l++) begin
      len_ind = 5'(l);
      repeat (4) @(negedge clk);
      rd_chk(3, "R6 length field clamp");
    end
    len_ind = 5'd7;

    // R7 unimplemented addresses
    for (int a = 5; a < 128; a++) begin
      wr(a, 8'hFF);
      rd_chk(a, "R7 unimplemented read is 00h");
    end
    chk(reg_bus === exp_bus(), "R7 no register changed by unimplemented writes",
        reg_bus, exp_bus());

    // R8 aborted frames
    xfer(1'b0, 7'd2, 8'hE1, 12, 1'b1, v, ok);
    rd_chk(2, "R8 abort after 12 bits");
    xfer(1'b0, 7'd2, 8'hE1, 15, 1'b1, v, ok);
    rd_chk(2, "R8 abort after 15 bits");
    wr(2, 8'h96);
    rd_chk(2, "R8 next full frame decodes from start");

    // R9 strap mode
    reg_en = 1'b0;
    repeat (4) @(negedge clk);
    xfer(1'b0, 7'd1, 8'hE7, 16, 1'b0, v, ok);
    xfer(1'b1, 7'd1, 8'h00, 16, 1'b0, v, ok);
    chk(ok, "R9 oe stays low with access disabled", {39'd0, ok}, 40'd1);
    reg_en = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(1, "R9 write ignored with access disabled");
    chk(reg_bus === exp_bus(), "R9 register bus unchanged", reg_bus, exp_bus());

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule